// File: doc/BRIEF.md
# Packed Sign Application Unit

This block is a packed-integer datapath stage. It takes a data vector and a control vector, each up to 256 bits wide, and splits both into lanes of equal width. In each lane the data element is negated, cleared or passed on unchanged, depending on the signed value of the control element at the same index. A width code picks 8-, 16- or 32-bit lanes. A length code picks 64, 128 or 256 active bits. A mode input sets what happens to result bits above the active length: in three-operand mode they are cleared, and in legacy mode they are copied from a supplied prior destination value.

The operands are captured when `valid_in` is high. The result and an error flag are registered and appear one clock later with `valid_out`. A reserved width or length code gives an all-zero result with the error flag raised. A 256-bit request in legacy mode also raises the error flag, but leaves the result register holding its previous contents.

Top module: `psign_unit`

## Requirements
- R1: When a control element is negative as a signed value (its top bit is 1), the result element is the two's-complement negation of the data element, modulo the element width. The most negative value maps to itself, so 8'h80 stays 8'h80, and no flag is raised.
- R2: When a control element is exactly zero, the result element is zero.
- R3: When a control element is positive, the result element equals the data element.
- R4: Width code `lane_w` selects the element size: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits. Element i covers bits [i*size +: size] in `src_a`, `src_b` and `result`.
- R5: Length code `vlen` selects the active bits: 2'b00 = 64, 2'b01 = 128, 2'b10 = 256. The number of lanes is the active length divided by the element size.
- R6: When `legacy` is 0, every result bit at or above the active length is 0.
- R7: When `legacy` is 1, every result bit at or above the active length equals the same bit of `old_dst`.
- R8: If `lane_w` or `vlen` is 2'b11 on a captured request, the result is all zeros and `err` is 1. For a legal captured request that is not covered by R9, `err` is 0.
- R9: A captured request with `legacy` = 1 and `vlen` = 2'b10 sets `err` to 1 and leaves `result` unchanged.
- R10: `valid_out` is `valid_in` delayed by one clock. `result` and `err` change only in the cycle after a captured request. A synchronous active-high reset clears `valid_out`, `err` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Capture request |
| lane_w | input | 2 | Element width code |
| vlen | input | 2 | Active vector length code |
| legacy | input | 1 | 1 = keep bits above the active length from old_dst, 0 = clear them |
| src_a | input | 256 | Data vector |
| src_b | input | 256 | Control vector |
| old_dst | input | 256 | Prior destination contents, used in legacy mode |
| valid_out | output | 1 | Result valid, one clock after capture |
| result | output | 256 | Registered result vector |
| err | output | 1 | Reserved code or illegal legacy length on the last capture |

## Verification
The assertions that compare the result to values captured with `$past` assume the operands are stable only at the capture edge, and they compare only against that sampled copy. The upper-bit checks fire only for legal codes, so the assertions depend on the width and length codes being two-bit values with 2'b11 reserved. The stimulus changes inputs only on falling edges, pulses `valid_in` for a single cycle, and sends the illegal encodings only in their own dedicated cases. The data-dependent checks therefore always refer to one well-defined captured request.

// File: rtl/psign_pkg.sv
package psign_pkg;

    localparam int unsigned VEC_W = 256;

    typedef enum logic [1:0] {
        LW_8  = 2'b00,
        LW_16 = 2'b01,
        LW_32 = 2'b10,
        LW_RSV = 2'b11
    } lane_w_e;

    typedef enum logic [1:0] {
        VL_64  = 2'b00,
        VL_128 = 2'b01,
        VL_256 = 2'b10,
        VL_RSV = 2'b11
    } vlen_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_ZERO = 2'b01,
        ACT_NEG  = 2'b10
    } sign_act_e;

    typedef struct packed {
        logic             ok;
        logic             hold;
        logic [VEC_W-1:0] value;
    } stage_t;

    function automatic sign_act_e classify(input logic msb, input logic is_zero);
        if (msb)          return ACT_NEG;
        else if (is_zero) return ACT_ZERO;
        else              return ACT_KEEP;
    endfunction

    function automatic logic [9:0] active_bits(input logic [1:0] code);
        case (code)
            VL_64:   return 10'd64;
            VL_128:  return 10'd128;
            VL_256:  return 10'd256;
            default: return 10'd0;
        endcase
    endfunction

endpackage

// File: rtl/psign_elem.sv
module psign_elem
    import psign_pkg::*;
#(
    parameter int unsigned EW = 8
) (
    input  logic [EW-1:0] d,
    input  logic [EW-1:0] c,
    output logic [EW-1:0] y
);
    sign_act_e act;

    always_comb begin
        act = classify(c[EW-1], (c == '0));
        case (act)
            ACT_NEG:  y = '0 - d;
            ACT_ZERO: y = '0;
            default:  y = d;
        endcase
    end
endmodule

// File: rtl/psign_lanes.sv
module psign_lanes #(
    parameter int unsigned VW = 256,
    parameter int unsigned EW = 8
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] y
);
    localparam int unsigned NLANE = VW / EW;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        psign_elem #(.EW(EW)) u_elem (
            .d (a[i*EW +: EW]),
            .c (b[i*EW +: EW]),
            .y (y[i*EW +: EW])
        );
    end
endmodule

// File: rtl/psign_len_mask.sv
module psign_len_mask
    import psign_pkg::*;
#(
    parameter int unsigned VW = 256
) (
    input  logic [1:0]    vlen,
    output logic [VW-1:0] mask
);
    logic [9:0] act;

    assign act = active_bits(vlen);

    for (genvar i = 0; i < VW; i++) begin : g_bit
        assign mask[i] = (10'(i) < act);
    end
endmodule

// File: rtl/psign_unit.sv
module psign_unit
    import psign_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_in,
    input  logic [1:0]           lane_w,
    input  logic [1:0]           vlen,
    input  logic                 legacy,
    input  logic [VEC_W-1:0]     src_a,
    input  logic [VEC_W-1:0]     src_b,
    input  logic [VEC_W-1:0]     old_dst,
    output logic                 valid_out,
    output logic [VEC_W-1:0]     result,
    output logic                 err
);
    localparam int unsigned NW = 3;

    logic [VEC_W-1:0] by_w [NW];
    logic [VEC_W-1:0] lanes_sel;
    logic [VEC_W-1:0] mask;
    stage_t           nxt;

    for (genvar g = 0; g < NW; g++) begin : g_width
        psign_lanes #(.VW(VEC_W), .EW(8 << g)) u_lanes (
            .a (src_a),
            .b (src_b),
            .y (by_w[g])
        );
    end

    psign_len_mask #(.VW(VEC_W)) u_mask (
        .vlen (vlen),
        .mask (mask)
    );

    always_comb begin
        case (lane_w)
            LW_8:    lanes_sel = by_w[0];
            LW_16:   lanes_sel = by_w[1];
            default: lanes_sel = by_w[2];
        endcase

        nxt.ok    = 1'b1;
        nxt.hold  = 1'b0;
        nxt.value = (lanes_sel & mask) | (legacy ? (old_dst & ~mask) : '0);

        if (lane_w == LW_RSV || vlen == VL_RSV) begin
            nxt.ok    = 1'b0;
            nxt.value = '0;
        end else if (legacy && vlen == VL_256) begin
            nxt.ok   = 1'b0;
            nxt.hold = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            err       <= 1'b0;
            result    <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                err <= ~nxt.ok;
                if (!nxt.hold) result <= nxt.value;
            end
        end
    end
endmodule

// File: rtl/psign_unit_chk.sv
module psign_unit_chk
    import psign_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             valid_in,
    input logic [1:0]       lane_w,
    input logic [1:0]       vlen,
    input logic             legacy,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic [VEC_W-1:0] old_dst,
    input logic             valid_out,
    input logic [VEC_W-1:0] result,
    input logic             err
);
    logic legal;
    assign legal = (lane_w != 2'b11) && (vlen != 2'b11);

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(result) && $stable(err)));
    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !legal) |=> (err && result == '0));
    assert_legacy_256_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_in && legal && legacy && vlen == 2'b10) |=> (err && $stable(result)));
    assert_upper_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_in && legal && !legacy && vlen == 2'b00) |=> (result[VEC_W-1:64] == '0 && !err));
    assert_upper_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_in && legal && legacy && vlen == 2'b01)
        |=> (result[VEC_W-1:128] == $past(old_dst[VEC_W-1:128])));
endmodule

bind psign_unit psign_unit_chk u_chk (.*);

// File: tb/test_psign_unit.sv
module test_psign_unit;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          valid_in;
    logic [1:0]    lane_w;
    logic [1:0]    vlen;
    logic          legacy;
    logic [VW-1:0] src_a;
    logic [VW-1:0] src_b;
    logic [VW-1:0] old_dst;
    logic          valid_out;
    logic [VW-1:0] result;
    logic          err;

    int n_checks = 0;
    int n_errs   = 0;
    logic          done = 1'b0;
    logic [VW-1:0] last_res;

    always #(CLK_PERIOD/2) clk = ~clk;

    psign_unit i_psign_unit (
        .clk(clk), .rst(rst), .valid_in(valid_in), .lane_w(lane_w), .vlen(vlen),
        .legacy(legacy), .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
        .valid_out(valid_out), .result(result), .err(err)
    );

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom();
        return v;
    endfunction

    function automatic logic [VW-1:0] model(input int w, input int l, input logic leg,
                                            input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [VW-1:0] od);
        logic [VW-1:0] r = '0;
        int ew  = 8 << w;
        int act = 64 << l;
        for (int e = 0; e < act/ew; e++) begin
            logic [31:0] av = '0;
            logic [31:0] bv = '0;
            logic [31:0] rv;
            for (int k = 0; k < ew; k++) begin
                av[k] = a[e*ew+k];
                bv[k] = b[e*ew+k];
            end
            if (bv[ew-1])      rv = 32'd0 - av;
            else if (bv == 0)  rv = 32'd0;
            else               rv = av;
            for (int k = 0; k < ew; k++) r[e*ew+k] = rv[k];
        end
        for (int i = act; i < VW; i++) r[i] = leg ? od[i] : 1'b0;
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [VW-1:0] act,
                             input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: result=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: got=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive on a falling edge, capture at the next rising edge, sample on the falling edge after it.
    task automatic issue(input logic [1:0] w, input logic [1:0] l, input logic leg,
                         input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [VW-1:0] od);
        @(negedge clk);
        lane_w = w; vlen = l; legacy = leg;
        src_a = a; src_b = b; old_dst = od;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: run did not complete, got=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] a, b, od, exp;
        rst = 1'b1; valid_in = 1'b0; lane_w = 2'b00; vlen = 2'b00; legacy = 1'b0;
        src_a = '0; src_b = '0; old_dst = '0;
        repeat (3) @(negedge clk);
        check_bit("R10 reset valid_out", valid_out, 1'b0);
        check_bit("R10 reset err", err, 1'b0);
        check_vec("R10 reset result", result, '0);
        rst = 1'b0;

        // R1: all-negative control, data holds each width's minimum value
        a = {32{8'h80}}; b = {VW{1'b1}}; od = rnd_vec();
        issue(2'b00, 2'b10, 1'b0, a, b, od);
        check_vec("R1 byte min wrap", result, {32{8'h80}});
        check_bit("R1 no flag", err, 1'b0);
        a = {16{16'h8000}};
        issue(2'b01, 2'b10, 1'b0, a, b, od);
        check_vec("R1 word min wrap", result, {16{16'h8000}});
        a = {8{32'h0000_0005}};
        issue(2'b10, 2'b10, 1'b0, a, b, od);
        check_vec("R1 dword negate", result, {8{32'hFFFF_FFFB}});

        // R2: zero control clears every element
        a = rnd_vec();
        issue(2'b00, 2'b10, 1'b0, a, '0, od);
        check_vec("R2 zero control", result, '0);

        // R3: positive control passes data
        issue(2'b10, 2'b10, 1'b0, a, {8{32'h0000_0001}}, od);
        check_vec("R3 positive pass", result, a);

        // R4 R5 R6 R7: sweep every legal width, length and mode
        for (int w = 0; w < 3; w++)
            for (int l = 0; l < 3; l++)
                for (int m = 0; m < 2; m++)
                    for (int p = 0; p < 6; p++) begin
                        int ew;
                        if (m == 1 && l == 2) continue;
                        ew = 8 << w;
                        a = rnd_vec(); b = rnd_vec(); od = rnd_vec();
                        for (int e = 0; e < VW/ew; e++) begin
                            if ((e + p) % 3 == 0)
                                for (int k = 0; k < ew; k++) b[e*ew+k] = 1'b0;
                            if ((e + p) % 4 == 1) begin
                                for (int k = 0; k < ew; k++) a[e*ew+k] = 1'b0;
                                a[e*ew+ew-1] = 1'b1;
                            end
                        end
                        exp = model(w, l, m[0], a, b, od);
                        issue(2'(w), 2'(l), m[0], a, b, od);
                        check_vec(m == 0 ? "R4 R5 R6 sweep" : "R4 R5 R7 sweep", result, exp);
                        check_bit("R10 valid_out", valid_out, 1'b1);
                    end

        // R10: idle cycles keep result and drop valid_out
        last_res = result;
        @(negedge clk);
        src_a = rnd_vec(); src_b = rnd_vec();
        @(negedge clk);
        check_vec("R10 idle hold", result, last_res);
        check_bit("R10 idle valid", valid_out, 1'b0);

        // R8: reserved codes
        issue(2'b11, 2'b01, 1'b0, rnd_vec(), rnd_vec(), rnd_vec());
        check_vec("R8 reserved width result", result, '0);
        check_bit("R8 reserved width err", err, 1'b1);
        issue(2'b00, 2'b11, 1'b1, rnd_vec(), rnd_vec(), rnd_vec());
        check_vec("R8 reserved length result", result, '0);
        check_bit("R8 reserved length err", err, 1'b1);

        // R9: legacy 256 is refused and result is held
        a = rnd_vec(); b = rnd_vec(); od = rnd_vec();
        exp = model(1, 1, 1'b0, a, b, od);
        issue(2'b01, 2'b01, 1'b0, a, b, od);
        check_bit("R8 legal clears err", err, 1'b0);
        issue(2'b00, 2'b10, 1'b1, rnd_vec(), rnd_vec(), rnd_vec());
        check_vec("R9 legacy 256 held", result, exp);
        check_bit("R9 legacy 256 err", err, 1'b1);

        // R10: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_vec("R10 reset clears result", result, '0);
        check_bit("R10 reset clears err", err, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule